// File: doc/BRIEF.md
# Release Consistency Ordering Unit

This block is a per-core issue controller placed between a core's memory request stream and a memory system that may finish requests in any order. Each request carries a class: plain read, plain write, acquire or release. The unit forwards a request to the memory side only when release-consistency ordering allows it. Plain accesses wait for every earlier acquire to finish. A release waits for every earlier plain access to finish. Acquires and releases go out one at a time, in the order they were presented. A release does not hold back later plain accesses. Earlier plain accesses do not hold back an acquire.

Requests arrive in program order on a valid/ready port and leave on a second valid/ready port in the same order. The request side sees back-pressure in two cases: the memory side is not ready, or the head request is held by an ordering rule. A held request stays at the head and blocks every request behind it. There is no internal buffering: the payload passes straight through in the cycle it is accepted. The memory side reports each finished request with a one-cycle completion pulse that carries the class of that request. An acquire is the read of a synchronisation variable and a release is the write to it. Both leave on the same port as plain traffic.

Top module: `rc_order_unit`

## Requirements
- R1: A plain request (class 2'b00 read, 2'b01 write) is not issued while an acquire (class 2'b10) is outstanding.
- R2: A release (class 2'b11) is not issued while any plain request is outstanding.
- R3: An acquire or release is not issued while another acquire or release is outstanding, so these requests finish in presentation order.
- R4: An acquire may issue while plain requests are outstanding. A plain request may issue while a release is outstanding.
- R5: When the head request is allowed, `mem_valid` equals `req_valid`, `req_ready` equals `mem_ready`, and class, address and data pass through unchanged. When the head request is held, both `mem_valid` and `req_ready` are 0.
- R6: A completion decrements only the tracker of its own class. Read and write completions both retire one outstanding plain request.
- R7: At most ORD_MAX plain requests are outstanding. A further plain request stalls until one completes.
- R8: A completion whose class has nothing outstanding is ignored.
- R9: A completion takes effect on the cycle after its pulse. In the pulse cycle, the request it unblocks is still held.
- R10: After reset nothing is outstanding, and an idle port shows `req_ready` high for any class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted this cycle when valid |
| req_kind | input | 2 | Request class: 00 read, 01 write, 10 acquire, 11 release |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Request valid toward memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_kind | output | 2 | Forwarded class |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded write data |
| done_valid | input | 1 | One-cycle completion pulse from memory |
| done_kind | input | 2 | Class of the completed request |

## Verification
The assertions keep their own count of outstanding requests, built from the handshakes and completions at the ports. On every cycle they check that each issue obeys the acquire, release, FIFO and limit rules. They also check that the two handshakes fire together with an unchanged payload, and that an allowed head request is never refused. The bench checks what needs a chosen history. It checks the one-cycle delay before a completion takes effect. It checks that stray completions of an idle class are ignored, and that a write completion retires a read. It checks that the unit fills up to its exact plain-request limit. A long random phase, with out-of-order completions and a memory side that sometimes stalls, is compared against a behavioural model on every cycle.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    RC_RD  = 2'b00,
    RC_WR  = 2'b01,
    RC_ACQ = 2'b10,
    RC_REL = 2'b11
  } rc_kind_e;

  localparam int RC_NSYNC = 2;
  localparam int RC_SYNC_ACQ = 0;
  localparam int RC_SYNC_REL = 1;

  function automatic logic rc_is_plain(input logic [1:0] k);
    return ~k[1];
  endfunction

  function automatic logic rc_is_sync(input logic [1:0] k, input int idx);
    return k[1] && (k[0] == idx[0]);
  endfunction
endpackage

// File: rtl/rc_ord_counter.sv
module rc_ord_counter #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic is_zero,
  output logic is_full
);
  localparam int CW = $clog2(MAX + 1);
  localparam logic [CW-1:0] MAX_C = CW'(MAX);

  logic [CW-1:0] count;
  logic          dec_ok;

  // a retire with nothing outstanding is dropped
  assign dec_ok  = dec && (count != '0);
  assign is_zero = (count == '0);
  assign is_full = (count == MAX_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && !dec_ok) begin
      count <= count + 1'b1;
    end else if (!inc && dec_ok) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rc_sync_tracker.sv
module rc_sync_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (set) begin
      busy <= 1'b1;
    end else if (clr) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rc_issue_gate.sv
module rc_issue_gate
  import rc_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       ord_zero,
  input  logic       ord_full,
  input  logic       acq_busy,
  input  logic       rel_busy,
  output logic       allow
);
  logic sync_busy;
  assign sync_busy = acq_busy | rel_busy;

  always_comb begin
    unique case (rc_kind_e'(kind))
      RC_RD, RC_WR: allow = !acq_busy && !ord_full;
      RC_ACQ:       allow = !sync_busy;
      RC_REL:       allow = !sync_busy && ord_zero;
      default:      allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/rc_order_unit.sv
module rc_order_unit
  import rc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ORD_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [1:0]        mem_kind,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              done_valid,
  input  logic [1:0]        done_kind
);
  logic                allow;
  logic                fire;
  logic                ord_zero, ord_full;
  logic [RC_NSYNC-1:0] sync_set, sync_clr, sync_busy;

  assign fire = req_valid && req_ready;

  rc_ord_counter #(.MAX(ORD_MAX)) u_ord (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (fire && rc_is_plain(req_kind)),
    .dec     (done_valid && rc_is_plain(done_kind)),
    .is_zero (ord_zero),
    .is_full (ord_full)
  );

  for (genvar g = 0; g < RC_NSYNC; g++) begin : g_sync
    assign sync_set[g] = fire && rc_is_sync(req_kind, g);
    assign sync_clr[g] = done_valid && rc_is_sync(done_kind, g);
    rc_sync_tracker u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (sync_set[g]),
      .clr   (sync_clr[g]),
      .busy  (sync_busy[g])
    );
  end

  rc_issue_gate u_gate (
    .kind     (req_kind),
    .ord_zero (ord_zero),
    .ord_full (ord_full),
    .acq_busy (sync_busy[RC_SYNC_ACQ]),
    .rel_busy (sync_busy[RC_SYNC_REL]),
    .allow    (allow)
  );

  assign req_ready = mem_ready && allow;
  assign mem_valid = req_valid && allow;
  assign mem_kind  = req_kind;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
endmodule

// File: rtl/rc_order_checker.sv
module rc_order_checker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ORD_MAX = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [1:0]        mem_kind,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done_valid,
  input logic [1:0]        done_kind
);
  int  sh_ord, sh_acq, sh_rel;
  logic go;
  assign go = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ord <= 0; sh_acq <= 0; sh_rel <= 0;
    end else begin
      sh_ord <= sh_ord + ((go && !mem_kind[1]) ? 1 : 0)
                - ((done_valid && !done_kind[1] && sh_ord > 0) ? 1 : 0);
      sh_acq <= sh_acq + ((go && mem_kind == 2'b10) ? 1 : 0)
                - ((done_valid && done_kind == 2'b10 && sh_acq > 0) ? 1 : 0);
      sh_rel <= sh_rel + ((go && mem_kind == 2'b11) ? 1 : 0)
                - ((done_valid && done_kind == 2'b11 && sh_rel > 0) ? 1 : 0);
    end
  end

  p_plain_after_acq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !mem_kind[1]) |-> sh_acq == 0);
  p_rel_after_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mem_kind == 2'b11) |-> sh_ord == 0);
  p_sync_fifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mem_kind[1]) |-> (sh_acq == 0 && sh_rel == 0));
  p_acq_not_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10 && mem_ready && sh_acq == 0 && sh_rel == 0) |-> req_ready);
  p_plain_not_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind[1] && mem_ready && sh_acq == 0 && sh_ord < ORD_MAX) |-> req_ready);
  p_lockstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) == (mem_valid && mem_ready));
  p_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_kind == req_kind && mem_addr == req_addr && mem_wdata == req_wdata));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !mem_kind[1]) |-> sh_ord < ORD_MAX);
endmodule

bind rc_order_unit rc_order_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ORD_MAX(ORD_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .done_valid(done_valid), .done_kind(done_kind)
);

// File: tb/tb_rc_order_unit.sv
module tb_rc_order_unit;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int OMAX = 4;
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_ACQ = 2'b10, K_REL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_ready, mem_valid, mem_ready = 1'b1;
  logic [1:0]    req_kind = K_REL, mem_kind, done_kind = 2'b00;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] req_wdata = '0, mem_wdata;
  logic          done_valid = 1'b0;

  rc_order_unit #(.ADDR_W(AW), .DATA_W(DW), .ORD_MAX(OMAX)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done_valid(done_valid), .done_kind(done_kind)
  );

  typedef struct { logic [1:0] k; logic [AW-1:0] a; logic [DW-1:0] d; } req_t;
  req_t       stim[$];
  logic [1:0] outq[$];
  int ord_o = 0, acq_o = 0, rel_o = 0;
  int checks = 0, bad = 0;
  int inj = -1;
  bit hold = 1'b1, rnd_ready = 1'b0;

  function automatic bit allow(input logic [1:0] k);
    if (!k[1]) return (acq_o == 0) && (ord_o < OMAX);
    if (k == K_ACQ) return (acq_o == 0) && (rel_o == 0);
    return (acq_o == 0) && (rel_o == 0) && (ord_o == 0);
  endfunction

  function automatic string tag_for(input logic [1:0] k);
    if (!k[1]) return (acq_o > 0) ? "R1" : ((ord_o >= OMAX) ? "R7" : "R5");
    if (acq_o > 0 || rel_o > 0) return "R3";
    if (k == K_ACQ) return "R4";
    return (ord_o > 0) ? "R2" : "R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k);
    req_t r;
    r.k = k; r.a = AW'($urandom); r.d = $urandom;
    stim.push_back(r);
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #3; end
  endtask

  function automatic void retire(input logic [1:0] k);
    if (!k[1]) begin
      if (ord_o > 0) begin
        ord_o--;
        for (int i = 0; i < outq.size(); i++)
          if (!outq[i][1]) begin outq.delete(i); break; end
      end
    end else begin
      if ((k == K_ACQ && acq_o > 0) || (k == K_REL && rel_o > 0)) begin
        if (k == K_ACQ) acq_o--; else rel_o--;
        for (int i = 0; i < outq.size(); i++)
          if (outq[i] == k) begin outq.delete(i); break; end
      end
    end
  endfunction

  // driver and per-cycle reference comparison
  initial begin
    bit exp_fire;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    forever begin
      @(negedge clk);
      if (stim.size() > 0) begin
        req_valid = 1'b1; req_kind = stim[0].k; req_addr = stim[0].a; req_wdata = stim[0].d;
      end else begin
        req_valid = 1'b0; req_kind = K_REL; req_addr = '0; req_wdata = '0;
      end
      mem_ready = rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      done_valid = 1'b0; done_kind = 2'b00;
      if (inj >= 0) begin
        done_valid = 1'b1; done_kind = inj[1:0]; inj = -1;
      end else if (!hold && outq.size() > 0 && $urandom_range(0, 1) == 1) begin
        done_valid = 1'b1; done_kind = outq[$urandom_range(0, outq.size() - 1)];
      end
      #2;
      exp_fire = req_valid && mem_ready && allow(req_kind);
      chk(req_ready == (mem_ready && allow(req_kind)), tag_for(req_kind), "req_ready",
          req_ready, mem_ready && allow(req_kind));
      chk(mem_valid == (req_valid && allow(req_kind)), tag_for(req_kind), "mem_valid",
          mem_valid, req_valid && allow(req_kind));
      if (mem_valid)
        chk(mem_kind == req_kind && mem_addr == req_addr && mem_wdata == req_wdata,
            "R5", "payload", {mem_kind, mem_addr}, {req_kind, req_addr});
      @(posedge clk); #1;
      if (done_valid) retire(done_kind);
      if (exp_fire) begin
        outq.push_back(req_kind);
        if (!req_kind[1]) ord_o++; else if (req_kind == K_ACQ) acq_o++; else rel_o++;
        void'(stim.pop_front());
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (rst_n);
    step(1);
    chk(req_ready && !mem_valid, "R10", "idle ready/valid", {req_ready, mem_valid}, 2'b10);
    // R1: plain request held behind an acquire
    push(K_ACQ); push(K_RD);
    step(3);
    chk(req_valid && req_kind == K_RD && !mem_valid, "R1", "read behind acquire", mem_valid, 0);
    inj = K_ACQ;
    step(1);
    chk(done_valid && !req_ready, "R9", "ready in completion cycle", req_ready, 0);
    step(1);
    chk(req_ready && mem_valid, "R1", "read after acquire done", mem_valid, 1);
    // R2: release held behind an outstanding read
    push(K_REL);
    step(3);
    chk(req_kind == K_REL && !mem_valid, "R2", "release behind read", mem_valid, 0);
    inj = K_ACQ;   // stray: no acquire outstanding
    step(2);
    chk(!mem_valid, "R8", "stray acquire completion", mem_valid, 0);
    inj = K_WR;    // write completion retires the read
    step(2);
    chk(mem_valid && req_kind == K_REL, "R6", "write completion retires read", mem_valid, 1);
    // R4 / R3: plain passes an outstanding release, acquire waits for it
    push(K_RD); push(K_WR); push(K_ACQ);
    step(4);
    chk(ord_o == 2 && rel_o == 1, "R4", "plain issued past release", ord_o, 2);
    chk(req_kind == K_ACQ && !mem_valid, "R3", "acquire behind release", mem_valid, 0);
    inj = K_REL;
    step(2);
    chk(mem_valid && req_kind == K_ACQ, "R4", "acquire with plain outstanding", ord_o, 2);
    push(K_RD);
    step(3);
    inj = K_ACQ;
    step(3);
    // R7: fill to the limit
    repeat (6) push(K_RD);
    step(8);
    chk(!mem_valid && ord_o == OMAX, "R7", "plain limit", ord_o, OMAX);
    // random phase
    hold = 1'b0; rnd_ready = 1'b1;
    repeat (800) begin
      int r = $urandom_range(0, 9);
      push(r < 4 ? K_RD : (r < 7 ? K_WR : (r < 8 ? K_ACQ : K_REL)));
    end
    while (stim.size() > 0 || outq.size() > 0) step(1);
    step(4);
    chk(ord_o == 0 && acq_o == 0 && rel_o == 0, "R6", "all drained", ord_o + acq_o + rel_o, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule